// File: doc/BRIEF.md
# Integer Execute Stage with Operation Decode

This block is the integer execute stage of a 32-bit load/store RISC datapath. It receives one instruction word together with the two source register values that were already read for it. In the same cycle it decodes the word and computes the result. It also returns the index of the register to be written, a write strobe, a trap flag for signed overflow and a flag for words it does not recognise. The block has no state: it sits between operand read and writeback, and writeback commits the result only when the write strobe is high.

Two word layouts are understood. The register layout has opcode 0 in bits 31:26, the destination in bits 15:11, a constant shift amount in bits 10:6 and an operation selector in bits 5:0. The immediate layout has the operation in bits 31:26, the destination in bits 20:16 and a 16-bit constant in bits 15:0. The first source register value is called `rs`. The second is called `rt`, and it is the value that shifts move.

Top module: `int_exec_unit`

## Requirements
- R1: With opcode 0, selector 0x20 gives rs+rt, 0x21 gives rs+rt, 0x22 gives rs-rt and 0x23 gives rs-rt, all modulo 2^32.
- R2: With opcode 0, selector 0x24 gives rs AND rt, 0x25 gives rs OR rt, 0x26 gives rs XOR rt and 0x27 gives NOT(rs OR rt).
- R3: With opcode 0, selectors 0x00, 0x02 and 0x03 shift rt left logically, right logically and right arithmetically by bits 10:6 of the word. A logical shift fills with zeros and an arithmetic shift fills with copies of bit 31.
- R4: With opcode 0, selectors 0x04, 0x06 and 0x07 perform the same three shifts, with the distance taken from bits 4:0 of rs. The upper bits of rs have no effect.
- R5: With opcode 0, selector 0x2a gives 1 when rs < rt as two's-complement numbers and 0 otherwise. Selector 0x2b gives the same result for an unsigned comparison.
- R6: Opcodes 0x08 and 0x09 give rs plus the sign-extended 16-bit constant. Opcodes 0x0c, 0x0d and 0x0e give rs AND, OR and XOR the zero-extended constant.
- R7: Opcode 0x0f gives the 16-bit constant in result bits 31:16, with bits 15:0 cleared. rs has no effect.
- R8: Opcode 0x0a gives 1 when rs is below the sign-extended constant as signed numbers. Opcode 0x0b sign-extends the constant first and then compares unsigned.
- R9: The destination index is word bits 15:11 for opcode 0 and word bits 20:16 for every immediate opcode.
- R10: Signed overflow on selectors 0x20 and 0x22 or on opcode 0x08 raises the overflow flag and holds the write strobe low. Selectors 0x21 and 0x23 and opcode 0x09 wrap silently and never raise the flag.
- R11: Any opcode or selector not listed above raises the illegal flag, holds the write strobe low and keeps the overflow flag low.
- R12: Every recognised operation that does not overflow raises the write strobe and keeps both flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | First source register value |
| rt_val_i | input | 32 | Second source register value |
| result_o | output | 32 | Computed result |
| dst_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Register write strobe |
| ovf_exc_o | output | 1 | Signed-overflow trap |
| illegal_o | output | 1 | Unrecognised instruction |

## Verification
The bench builds the block with its default 32-bit datapath. Every constant in the encoding (field positions, 5-bit shift distances, 16-bit constants) therefore keeps its true width. This width brings the sign-boundary cases within reach: adding one to the largest positive value, subtracting one from the most negative value, and shifting by 31. It also covers signed and unsigned compares whose answers differ only because bit 31 is set. The table drives each selector and each immediate opcode with operands chosen so that a wrong fill, a wrong extension or a wrong destination field would show in the result.

// File: rtl/iexu_pkg.sv
package iexu_pkg;

    localparam int XLEN    = 32;
    localparam int REG_W   = 5;
    localparam int OPC_W   = 6;
    localparam int IMM_W   = 16;
    localparam int SHAMT_W = $clog2(XLEN);

    localparam int OPC_LSB = XLEN - OPC_W;
    localparam int RT_LSB  = OPC_LSB - 2 * REG_W;
    localparam int RD_LSB  = RT_LSB - REG_W;
    localparam int SH_LSB  = RD_LSB - REG_W;

    // major opcodes
    localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
    localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
    localparam logic [OPC_W-1:0] OPC_ADDIU = 6'h09;
    localparam logic [OPC_W-1:0] OPC_SLTI  = 6'h0a;
    localparam logic [OPC_W-1:0] OPC_SLTIU = 6'h0b;
    localparam logic [OPC_W-1:0] OPC_ANDI  = 6'h0c;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0d;
    localparam logic [OPC_W-1:0] OPC_XORI  = 6'h0e;
    localparam logic [OPC_W-1:0] OPC_LUI   = 6'h0f;

    // register-layout selectors
    localparam logic [5:0] SEL_SLL  = 6'h00;
    localparam logic [5:0] SEL_SRL  = 6'h02;
    localparam logic [5:0] SEL_SRA  = 6'h03;
    localparam logic [5:0] SEL_SLLV = 6'h04;
    localparam logic [5:0] SEL_SRLV = 6'h06;
    localparam logic [5:0] SEL_SRAV = 6'h07;
    localparam logic [5:0] SEL_ADD  = 6'h20;
    localparam logic [5:0] SEL_ADDU = 6'h21;
    localparam logic [5:0] SEL_SUB  = 6'h22;
    localparam logic [5:0] SEL_SUBU = 6'h23;
    localparam logic [5:0] SEL_AND  = 6'h24;
    localparam logic [5:0] SEL_OR   = 6'h25;
    localparam logic [5:0] SEL_XOR  = 6'h26;
    localparam logic [5:0] SEL_NOR  = 6'h27;
    localparam logic [5:0] SEL_SLT  = 6'h2a;
    localparam logic [5:0] SEL_SLTU = 6'h2b;

    typedef enum logic [3:0] {
        FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR, FN_NOR,
        FN_SHL, FN_SHR, FN_SAR, FN_LTS, FN_LTU, FN_PASSB
    } fn_e;

    typedef enum logic [1:0] {
        K_REG,   // operand B is rt
        K_SEXT,  // sign-extended constant
        K_ZEXT,  // zero-extended constant
        K_HIGH   // constant in the upper half
    } kind_e;

    typedef struct packed {
        fn_e              fn;
        kind_e            kind;
        logic             var_sh;
        logic             traps;
        logic             legal;
        logic [REG_W-1:0] dst;
    } ctl_t;

    function automatic logic [XLEN-1:0] widen_imm(input kind_e k,
                                                  input logic [IMM_W-1:0] c);
        case (k)
            K_SEXT:  return {{(XLEN-IMM_W){c[IMM_W-1]}}, c};
            K_ZEXT:  return {{(XLEN-IMM_W){1'b0}}, c};
            K_HIGH:  return {c, {(XLEN-IMM_W){1'b0}}};
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/iexu_decode.sv
module iexu_decode
    import iexu_pkg::*;
(
    input  logic [XLEN-1:0] instr_i,
    output ctl_t            ctl_o
);
    logic [OPC_W-1:0] opc;
    logic [5:0]       sel;
    logic             unused_rs_field;

    assign opc = instr_i[XLEN-1:OPC_LSB];
    assign sel = instr_i[5:0];
    assign unused_rs_field = ^instr_i[OPC_LSB-1:OPC_LSB-REG_W];

    always_comb begin
        ctl_o        = '0;
        ctl_o.fn     = FN_ADD;
        ctl_o.kind   = K_REG;
        ctl_o.legal  = 1'b1;
        ctl_o.dst    = instr_i[RT_LSB+REG_W-1:RT_LSB];
        if (opc == OPC_REG) begin
            ctl_o.dst = instr_i[RD_LSB+REG_W-1:RD_LSB];
            case (sel)
                SEL_ADD:  begin ctl_o.fn = FN_ADD; ctl_o.traps = 1'b1; end
                SEL_ADDU: ctl_o.fn = FN_ADD;
                SEL_SUB:  begin ctl_o.fn = FN_SUB; ctl_o.traps = 1'b1; end
                SEL_SUBU: ctl_o.fn = FN_SUB;
                SEL_AND:  ctl_o.fn = FN_AND;
                SEL_OR:   ctl_o.fn = FN_OR;
                SEL_XOR:  ctl_o.fn = FN_XOR;
                SEL_NOR:  ctl_o.fn = FN_NOR;
                SEL_SLL:  ctl_o.fn = FN_SHL;
                SEL_SRL:  ctl_o.fn = FN_SHR;
                SEL_SRA:  ctl_o.fn = FN_SAR;
                SEL_SLLV: begin ctl_o.fn = FN_SHL; ctl_o.var_sh = 1'b1; end
                SEL_SRLV: begin ctl_o.fn = FN_SHR; ctl_o.var_sh = 1'b1; end
                SEL_SRAV: begin ctl_o.fn = FN_SAR; ctl_o.var_sh = 1'b1; end
                SEL_SLT:  ctl_o.fn = FN_LTS;
                SEL_SLTU: ctl_o.fn = FN_LTU;
                default:  ctl_o.legal = 1'b0;
            endcase
        end else begin
            case (opc)
                OPC_ADDI:  begin ctl_o.fn = FN_ADD; ctl_o.kind = K_SEXT;
                                 ctl_o.traps = 1'b1; end
                OPC_ADDIU: begin ctl_o.fn = FN_ADD; ctl_o.kind = K_SEXT; end
                OPC_SLTI:  begin ctl_o.fn = FN_LTS; ctl_o.kind = K_SEXT; end
                OPC_SLTIU: begin ctl_o.fn = FN_LTU; ctl_o.kind = K_SEXT; end
                OPC_ANDI:  begin ctl_o.fn = FN_AND; ctl_o.kind = K_ZEXT; end
                OPC_ORI:   begin ctl_o.fn = FN_OR;  ctl_o.kind = K_ZEXT; end
                OPC_XORI:  begin ctl_o.fn = FN_XOR; ctl_o.kind = K_ZEXT; end
                OPC_LUI:   begin ctl_o.fn = FN_PASSB; ctl_o.kind = K_HIGH; end
                default:   ctl_o.legal = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/iexu_operand.sv
module iexu_operand
    import iexu_pkg::*;
(
    input  ctl_t               ctl_i,
    input  logic [XLEN-1:0]    instr_i,
    input  logic [XLEN-1:0]    rs_val_i,
    input  logic [XLEN-1:0]    rt_val_i,
    output logic [XLEN-1:0]    opb_o,
    output logic [SHAMT_W-1:0] shamt_o
);
    always_comb begin
        if (ctl_i.kind == K_REG)
            opb_o = rt_val_i;
        else
            opb_o = widen_imm(ctl_i.kind, instr_i[IMM_W-1:0]);
    end

    assign shamt_o = ctl_i.var_sh ? rs_val_i[SHAMT_W-1:0]
                                  : instr_i[SH_LSB+SHAMT_W-1:SH_LSB];
endmodule

// File: rtl/iexu_alu.sv
module iexu_alu
    import iexu_pkg::*;
(
    input  fn_e                fn_i,
    input  logic [XLEN-1:0]    opa_i,
    input  logic [XLEN-1:0]    opb_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    output logic [XLEN-1:0]    res_o,
    output logic               ovf_o
);
    localparam int MSB = XLEN - 1;

    logic            sub;
    logic [XLEN-1:0] b_eff;
    logic [XLEN-1:0] sum;

    assign sub   = (fn_i == FN_SUB);
    assign b_eff = sub ? ~opb_i : opb_i;
    assign sum   = opa_i + b_eff + {{(XLEN-1){1'b0}}, sub};

    // same-sign operands whose sum changes sign
    assign ovf_o = (fn_i == FN_ADD || fn_i == FN_SUB)
                 && (opa_i[MSB] == b_eff[MSB]) && (sum[MSB] != opa_i[MSB]);

    always_comb begin
        case (fn_i)
            FN_ADD, FN_SUB: res_o = sum;
            FN_AND:   res_o = opa_i & opb_i;
            FN_OR:    res_o = opa_i | opb_i;
            FN_XOR:   res_o = opa_i ^ opb_i;
            FN_NOR:   res_o = ~(opa_i | opb_i);
            FN_SHL:   res_o = opb_i << shamt_i;
            FN_SHR:   res_o = opb_i >> shamt_i;
            FN_SAR:   res_o = $unsigned($signed(opb_i) >>> shamt_i);
            FN_LTS:   res_o = {{(XLEN-1){1'b0}}, $signed(opa_i) < $signed(opb_i)};
            FN_LTU:   res_o = {{(XLEN-1){1'b0}}, opa_i < opb_i};
            FN_PASSB: res_o = opb_i;
            default:  res_o = '0;
        endcase
    end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import iexu_pkg::*;
(
    input  logic [31:0] instr_i,
    input  logic [31:0] rs_val_i,
    input  logic [31:0] rt_val_i,
    output logic [31:0] result_o,
    output logic [4:0]  dst_o,
    output logic        wr_en_o,
    output logic        ovf_exc_o,
    output logic        illegal_o
);
    ctl_t               ctl;
    logic [XLEN-1:0]    opb;
    logic [SHAMT_W-1:0] shamt;
    logic [XLEN-1:0]    alu_res;
    logic               alu_ovf;

    iexu_decode u_dec (
        .instr_i (instr_i),
        .ctl_o   (ctl)
    );

    iexu_operand u_opnd (
        .ctl_i    (ctl),
        .instr_i  (instr_i),
        .rs_val_i (rs_val_i),
        .rt_val_i (rt_val_i),
        .opb_o    (opb),
        .shamt_o  (shamt)
    );

    iexu_alu u_alu (
        .fn_i    (ctl.fn),
        .opa_i   (rs_val_i),
        .opb_i   (opb),
        .shamt_i (shamt),
        .res_o   (alu_res),
        .ovf_o   (alu_ovf)
    );

    assign result_o  = ctl.legal ? alu_res : '0;
    assign dst_o     = ctl.dst;
    assign ovf_exc_o = ctl.legal & ctl.traps & alu_ovf;
    assign illegal_o = ~ctl.legal;
    assign wr_en_o   = ctl.legal & ~ovf_exc_o;
endmodule

// File: rtl/iexu_checker.sv
module iexu_checker (
    input logic [31:0] instr_i,
    input logic [31:0] rs_val_i,
    input logic [31:0] rt_val_i,
    input logic [31:0] result_o,
    input logic [4:0]  dst_o,
    input logic        wr_en_o,
    input logic        ovf_exc_o,
    input logic        illegal_o
);
    logic [5:0] opc;
    logic [5:0] sel;
    assign opc = instr_i[31:26];
    assign sel = instr_i[5:0];

    always_comb begin
        // R10: a trap never coexists with a write
        a_r10_trap_blocks_write: assert (!(ovf_exc_o && wr_en_o));
        // R11: rejected words neither write nor trap
        a_r11_illegal_quiet: assert (!illegal_o || (!wr_en_o && !ovf_exc_o));
        // R12: a recognised word either writes or traps
        a_r12_write_or_trap: assert (illegal_o || (wr_en_o != ovf_exc_o));
        // R10: wrapping forms never trap
        a_r10_wrap_no_flag: assert (!(((opc == 6'h00) && (sel == 6'h21 || sel == 6'h23))
                                       || opc == 6'h09) || !ovf_exc_o);
        // R5 and R8: compares return a single bit
        a_r5_compare_is_bit: assert (!(((opc == 6'h00) && (sel == 6'h2a || sel == 6'h2b))
                                        || opc == 6'h0a || opc == 6'h0b)
                                     || result_o[31:1] == 31'd0);
        // R7: upper-load clears the low half
        a_r7_lui_low_clear: assert (opc != 6'h0f || result_o[15:0] == 16'd0);
        // R9: destination field follows the layout
        a_r9_dst_field: assert (illegal_o
                                || dst_o == ((opc == 6'h00) ? instr_i[15:11]
                                                            : instr_i[20:16]));
    end

    logic unused_ok;
    assign unused_ok = ^{rs_val_i, rt_val_i};
endmodule

bind int_exec_unit iexu_checker u_chk (
    .instr_i   (instr_i),
    .rs_val_i  (rs_val_i),
    .rt_val_i  (rt_val_i),
    .result_o  (result_o),
    .dst_o     (dst_o),
    .wr_en_o   (wr_en_o),
    .ovf_exc_o (ovf_exc_o),
    .illegal_o (illegal_o)
);

// File: tb/int_exec_unit_test.sv
module int_exec_unit_test;

    typedef struct packed {
        logic [31:0] ins;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] res;
        logic [4:0]  dst;
        logic        we;
        logic        ovf;
        logic        ill;
        logic [7:0]  req;
    } vec_t;

    function automatic logic [31:0] rfmt(input logic [4:0] rd, input logic [4:0] sa,
                                         input logic [5:0] sel);
        return {6'h00, 5'd1, 5'd2, rd, sa, sel};
    endfunction

    function automatic logic [31:0] ifmt(input logic [5:0] opc, input logic [4:0] rt,
                                         input logic [15:0] k);
        return {opc, 5'd1, rt, k};
    endfunction

    localparam int NV = 33;
    localparam vec_t VEC [NV] = '{
        '{rfmt(5'd3, 5'd0, 6'h20), 32'd5, 32'd7, 32'd12, 5'd3, 1'b1, 1'b0, 1'b0, 8'd1},               // R1
        '{rfmt(5'd4, 5'd0, 6'h21), 32'h7fffffff, 32'd1, 32'h80000000, 5'd4, 1'b1, 1'b0, 1'b0, 8'd1},  // R1
        '{rfmt(5'd5, 5'd0, 6'h22), 32'd10, 32'd3, 32'd7, 5'd5, 1'b1, 1'b0, 1'b0, 8'd1},               // R1
        '{rfmt(5'd6, 5'd0, 6'h23), 32'd0, 32'd1, 32'hffffffff, 5'd6, 1'b1, 1'b0, 1'b0, 8'd1},         // R1
        '{rfmt(5'd7, 5'd0, 6'h24), 32'habcd1234, 32'hffff0000, 32'habcd0000, 5'd7, 1'b1, 1'b0, 1'b0, 8'd2}, // R2
        '{rfmt(5'd7, 5'd0, 6'h25), 32'habcd1234, 32'hffff0000, 32'hffff1234, 5'd7, 1'b1, 1'b0, 1'b0, 8'd2}, // R2
        '{rfmt(5'd7, 5'd0, 6'h26), 32'habcd1234, 32'hffff0000, 32'h54321234, 5'd7, 1'b1, 1'b0, 1'b0, 8'd2}, // R2
        '{rfmt(5'd7, 5'd0, 6'h27), 32'habcd1234, 32'hffff0000, 32'h0000edcb, 5'd7, 1'b1, 1'b0, 1'b0, 8'd2}, // R2
        '{rfmt(5'd8, 5'd8, 6'h00), 32'h0, 32'habcd1234, 32'hcd123400, 5'd8, 1'b1, 1'b0, 1'b0, 8'd3},     // R3
        '{rfmt(5'd8, 5'd4, 6'h03), 32'h0, 32'habcd1234, 32'hfabcd123, 5'd8, 1'b1, 1'b0, 1'b0, 8'd3},     // R3
        '{rfmt(5'd8, 5'd4, 6'h02), 32'h0, 32'habcd1234, 32'h0abcd123, 5'd8, 1'b1, 1'b0, 1'b0, 8'd3},     // R3
        '{rfmt(5'd8, 5'd31, 6'h03), 32'h0, 32'h80000000, 32'hffffffff, 5'd8, 1'b1, 1'b0, 1'b0, 8'd3},    // R3
        '{rfmt(5'd8, 5'd31, 6'h02), 32'h0, 32'h80000000, 32'h00000001, 5'd8, 1'b1, 1'b0, 1'b0, 8'd3},    // R3
        '{rfmt(5'd9, 5'd0, 6'h06), 32'd16, 32'habcd1234, 32'h0000abcd, 5'd9, 1'b1, 1'b0, 1'b0, 8'd4},    // R4
        '{rfmt(5'd9, 5'd0, 6'h07), 32'h00000024, 32'habcd1234, 32'hfabcd123, 5'd9, 1'b1, 1'b0, 1'b0, 8'd4}, // R4
        '{rfmt(5'd9, 5'd7, 6'h04), 32'hffffffe1, 32'h80000001, 32'h00000002, 5'd9, 1'b1, 1'b0, 1'b0, 8'd4}, // R4
        '{rfmt(5'd10, 5'd0, 6'h2a), 32'd1, 32'hffffffff, 32'd0, 5'd10, 1'b1, 1'b0, 1'b0, 8'd5},          // R5
        '{rfmt(5'd10, 5'd0, 6'h2b), 32'd1, 32'hffffffff, 32'd1, 5'd10, 1'b1, 1'b0, 1'b0, 8'd5},          // R5
        '{ifmt(6'h08, 5'd11, 16'hffff), 32'd10, 32'hdeadbeef, 32'd9, 5'd11, 1'b1, 1'b0, 1'b0, 8'd6},     // R6
        '{ifmt(6'h0c, 5'd12, 16'h8001), 32'hffffffff, 32'h0, 32'h00008001, 5'd12, 1'b1, 1'b0, 1'b0, 8'd6}, // R6
        '{ifmt(6'h0d, 5'd12, 16'h8000), 32'h12340000, 32'h0, 32'h12348000, 5'd12, 1'b1, 1'b0, 1'b0, 8'd6}, // R6
        '{ifmt(6'h0e, 5'd12, 16'hff00), 32'h0000ffff, 32'h0, 32'h000000ff, 5'd12, 1'b1, 1'b0, 1'b0, 8'd6}, // R6
        '{ifmt(6'h0f, 5'd13, 16'hac51), 32'hffffffff, 32'h0, 32'hac510000, 5'd13, 1'b1, 1'b0, 1'b0, 8'd7}, // R7
        '{ifmt(6'h0a, 5'd14, 16'hffff), 32'hfffffffe, 32'h0, 32'd1, 5'd14, 1'b1, 1'b0, 1'b0, 8'd8},      // R8
        '{ifmt(6'h0b, 5'd14, 16'hffff), 32'd5, 32'h0, 32'd1, 5'd14, 1'b1, 1'b0, 1'b0, 8'd8},             // R8
        '{ifmt(6'h0b, 5'd14, 16'hffff), 32'hffffffff, 32'h0, 32'd0, 5'd14, 1'b1, 1'b0, 1'b0, 8'd8},      // R8
        '{rfmt(5'd3, 5'd0, 6'h20), 32'h7fffffff, 32'd1, 32'h0, 5'd3, 1'b0, 1'b1, 1'b0, 8'd10},           // R10
        '{rfmt(5'd3, 5'd0, 6'h22), 32'h80000000, 32'd1, 32'h0, 5'd3, 1'b0, 1'b1, 1'b0, 8'd10},           // R10
        '{ifmt(6'h08, 5'd15, 16'h0001), 32'h7fffffff, 32'h0, 32'h0, 5'd15, 1'b0, 1'b1, 1'b0, 8'd10},     // R10
        '{ifmt(6'h09, 5'd15, 16'h0001), 32'h7fffffff, 32'h0, 32'h80000000, 5'd15, 1'b1, 1'b0, 1'b0, 8'd10}, // R10
        '{rfmt(5'd3, 5'd0, 6'h01), 32'd1, 32'd2, 32'h0, 5'd3, 1'b0, 1'b0, 1'b1, 8'd11},                  // R11
        '{ifmt(6'h3f, 5'd3, 16'h0000), 32'd1, 32'd2, 32'h0, 5'd3, 1'b0, 1'b0, 1'b1, 8'd11},              // R11
        '{ifmt(6'h02, 5'd3, 16'h1234), 32'd1, 32'd2, 32'h0, 5'd3, 1'b0, 1'b0, 1'b1, 8'd11}               // R11
    };

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [31:0] instr_i, rs_val_i, rt_val_i, result_o;
    logic [4:0]  dst_o;
    logic        wr_en_o, ovf_exc_o, illegal_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    int_exec_unit uut (
        .instr_i   (instr_i),
        .rs_val_i  (rs_val_i),
        .rt_val_i  (rt_val_i),
        .result_o  (result_o),
        .dst_o     (dst_o),
        .wr_en_o   (wr_en_o),
        .ovf_exc_o (ovf_exc_o),
        .illegal_o (illegal_o)
    );

    task automatic drive(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        instr_i  = ins;
        rs_val_i = a;
        rt_val_i = b;
        #2;
    endtask

    // result compared only when a write is expected; dst only when a write is expected
    task automatic check(input vec_t v);
        bit bad;
        n_chk++;
        bad = (wr_en_o != v.we) || (ovf_exc_o != v.ovf) || (illegal_o != v.ill)
           || (v.we && (result_o != v.res || dst_o != v.dst));
        if (bad) begin
            n_fail++;
            $display("FAIL R%0d ins=%h: got res=%h dst=%0d we=%b ovf=%b ill=%b, want res=%h dst=%0d we=%b ovf=%b ill=%b",
                     v.req, v.ins, result_o, dst_o, wr_en_o, ovf_exc_o, illegal_o,
                     v.res, v.dst, v.we, v.ovf, v.ill);
        end
    endtask

    task automatic run(input vec_t v);
        drive(v.ins, v.a, v.b);
        check(v);
    endtask

    initial begin
        instr_i = '0; rs_val_i = '0; rt_val_i = '0;
        repeat (2) @(posedge clk);

        // all-zero word: shift left by zero, rt passes through, R3 and R12
        run('{32'h0, 32'h0, 32'h0, 32'h0, 5'd0, 1'b1, 1'b0, 1'b0, 8'd12});

        for (int i = 0; i < NV; i++) run(VEC[i]);

        // R9: register layout with rd=31 and rt field 2 picks 31
        run('{rfmt(5'd31, 5'd0, 6'h25), 32'h1, 32'h2, 32'h3, 5'd31, 1'b1, 1'b0, 1'b0, 8'd9});
        // R9: immediate layout picks bits 20:16, ignoring bits 15:11 of the constant
        run('{ifmt(6'h0d, 5'd17, 16'hf800), 32'h0, 32'h0, 32'h0000f800, 5'd17, 1'b1, 1'b0, 1'b0, 8'd9});
        // R10: two negatives overflow into a positive
        run('{rfmt(5'd3, 5'd0, 6'h20), 32'h80000000, 32'h80000000, 32'h0, 5'd3, 1'b0, 1'b1, 1'b0, 8'd10});
        // R10: unsigned subtract across the boundary stays quiet
        run('{rfmt(5'd3, 5'd0, 6'h23), 32'h80000000, 32'd1, 32'h7fffffff, 5'd3, 1'b1, 1'b0, 1'b0, 8'd10});
        // R1: signed subtract of equal extremes, no overflow
        run('{rfmt(5'd3, 5'd0, 6'h22), 32'h80000000, 32'h80000000, 32'h0, 5'd3, 1'b1, 1'b0, 1'b0, 8'd1});
        // R7: upper-load ignores rs
        run('{ifmt(6'h0f, 5'd2, 16'h0001), 32'h12345678, 32'h0, 32'h00010000, 5'd2, 1'b1, 1'b0, 1'b0, 8'd7});

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule